// File: doc/BRIEF.md
# Single-Transfer Pipelined Bus Master

This block turns a simple command (a read/write flag, an address and write data) into one transfer on a pipelined Wishbone bus. It raises cycle and strobe together, holds the whole request steady while the subordinate stalls, and drops strobe once the request is taken. It keeps cycle high until acknowledge arrives, captures the data bus in that cycle, and then releases the bus.

Only one transfer is in flight at a time. The command side uses a valid/ready handshake, and ready is high only while the master is idle. Completion is reported by a one-cycle done pulse, together with the captured data, in the cycle after acknowledge. Between two transfers the bus always sees at least one idle cycle with cycle and strobe both low.

Top module: `wb_single_master`

## Requirements
- R1: A synchronous active-high reset puts the master in idle. In the cycle after reset, cycle, strobe and done are low and cmd_ready is high.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both high. In the next cycle cycle and strobe are both high, write-enable equals cmd_we, the address equals cmd_addr, and the write data bus carries cmd_wdata for a write (cmd_we=1) and zero for a read (cmd_we=0).
- R3: While strobe and stall are both high, strobe, write-enable, address and write data stay unchanged in the next cycle.
- R4: After an edge where strobe is high and stall is low (acceptance), strobe is low in the next cycle.
- R5: After acceptance, cycle stays high for any number of cycles until acknowledge is seen high.
- R6: The data bus value present in the acknowledge cycle appears on rdata, with done high for exactly one cycle, in the cycle after acknowledge. The data bus is not captured in any cycle without acknowledge.
- R7: Cycle is low in the cycle after acknowledge.
- R8: After cycle falls, it stays low for at least one more cycle before the next transfer starts.
- R9: Whenever cycle is low, address, write data and write-enable are driven to zero.
- R10: cmd_ready is low from the cycle a command is taken until the done cycle ends, and a command presented in that time starts no transfer and does not change the request on the bus.
- R11: Acknowledge and data presented while cycle is low are ignored: done stays low and rdata keeps its value.
- R12: An acknowledge that arrives in the same cycle as acceptance (strobe high, stall low) completes the transfer just like a later acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_we | input | 1 | 1 for write, 0 for read |
| cmd_addr | input | AW | Transfer address |
| cmd_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Data captured with acknowledge |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write-enable |
| wb_adr_o | output | AW | Bus address |
| wb_dat_o | output | DW | Bus write data |
| wb_stall_i | input | 1 | Subordinate stall |
| wb_ack_i | input | 1 | Subordinate acknowledge |
| wb_dat_i | input | DW | Subordinate read data |

## Verification
A wrong internal state shows up at the bus pins within one cycle: a master stuck in the request phase keeps strobe high past acceptance, one that falls out of the wait phase early drops cycle before acknowledge, and one that skips the completion phase either never pulses done or allows cmd_ready back with no idle gap. A wrongly latched command shows as an address, write-enable or data value that differs from the command in the first request cycle, or that drifts while stall is held. Capture errors show on rdata in the done cycle, which the bench makes visible by driving a different value on the data bus whenever acknowledge is low.

// File: rtl/wb_single_master.sv
module wb_single_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [AW-1:0] wb_adr_o,
  output logic [DW-1:0] wb_dat_o,
  input  logic          wb_stall_i,
  input  logic          wb_ack_i,
  input  logic [DW-1:0] wb_dat_i
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_t;

  state_t        st;
  logic          we_q;
  logic [AW-1:0] adr_q;
  logic [DW-1:0] dat_q;
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      we_q  <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
      rd_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          st    <= S_REQ;
          we_q  <= cmd_we;
          adr_q <= cmd_addr;
          dat_q <= cmd_we ? cmd_wdata : '0;
        end
        S_REQ: if (!wb_stall_i) begin
          if (wb_ack_i) begin
            st   <= S_DONE;
            rd_q <= wb_dat_i;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (wb_ack_i) begin
          st   <= S_DONE;
          rd_q <= wb_dat_i;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wb_cyc_o  = (st == S_REQ) || (st == S_WAIT);
  assign wb_stb_o  = (st == S_REQ);
  assign wb_we_o   = wb_cyc_o & we_q;
  assign wb_adr_o  = wb_cyc_o ? adr_q : '0;
  assign wb_dat_o  = wb_cyc_o ? dat_q : '0;
  assign cmd_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign rdata     = rd_q;

endmodule

// File: rtl/wb_single_master_chk.sv
module wb_single_master_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_ready,
  input logic          done,
  input logic          wb_cyc_o,
  input logic          wb_stb_o,
  input logic          wb_we_o,
  input logic [AW-1:0] wb_adr_o,
  input logic [DW-1:0] wb_dat_o,
  input logic          wb_stall_i,
  input logic          wb_ack_i
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!wb_cyc_o && !wb_stb_o && !done && cmd_ready));

  assert_stb_inside_cyc_R2: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> wb_cyc_o);

  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (wb_stb_o && wb_stall_i) |=>
      (wb_stb_o && $stable(wb_we_o) && $stable(wb_adr_o) && $stable(wb_dat_o)));

  assert_drop_stb_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_stb_o && !wb_stall_i) |=> !wb_stb_o);

  assert_cyc_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && !wb_stb_o && !wb_ack_i) |=> wb_cyc_o);

  assert_release_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_ack_i && !(wb_stb_o && wb_stall_i)) |=> (!wb_cyc_o && done));

  assert_idle_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(wb_cyc_o) |=> !wb_cyc_o);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !wb_cyc_o |-> (wb_adr_o == '0 && wb_dat_o == '0 && !wb_we_o));

  assert_ready_only_idle_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!wb_cyc_o && !done));

  assert_no_stray_done_R11: assert property (@(posedge clk) disable iff (rst)
    !wb_cyc_o |=> !done);

endmodule

bind wb_single_master wb_single_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .done(done),
  .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
  .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
  .wb_stall_i(wb_stall_i), .wb_ack_i(wb_ack_i)
);

// File: tb/tb_wb_single_master.sv
`timescale 1ns/1ps
module tb_wb_single_master;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          done;
  logic [DW-1:0] rdata;
  logic          wb_cyc_o, wb_stb_o, wb_we_o;
  logic [AW-1:0] wb_adr_o;
  logic [DW-1:0] wb_dat_o;
  logic          wb_stall_i = 1'b0;
  logic          wb_ack_i = 1'b0;
  logic [DW-1:0] wb_dat_i = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wb_single_master #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .done(done), .rdata(rdata),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
    .wb_stall_i(wb_stall_i), .wb_ack_i(wb_ack_i), .wb_dat_i(wb_dat_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!wb_cyc_o && !wb_stb_o && !done, "R1 bus idle", {wb_cyc_o, wb_stb_o, done}, 0);
    chk(cmd_ready, "R1 ready", cmd_ready, 1);
    chk(wb_adr_o == 0 && wb_dat_o == 0 && !wb_we_o, "R9 idle zero", wb_adr_o, 0);
  endtask

  // one transfer; ack_now = acknowledge in the acceptance cycle
  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [DW-1:0] rd, input int nstall, input int nwait,
                      input bit ack_now, input bit poke_busy);
    logic [DW-1:0] expd;
    expd = we ? wd : '0;
    @(negedge clk);
    chk(cmd_ready, "R10 ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_we = we; cmd_addr = a; cmd_wdata = wd;
    wb_dat_i = ~rd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_we = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    chk(wb_cyc_o && wb_stb_o, "R2 cyc and stb", {wb_cyc_o, wb_stb_o}, 2'b11);
    chk(wb_we_o == we && wb_adr_o == a, "R2 we/adr", wb_adr_o, a);
    chk(wb_dat_o == expd, "R2 write data", wb_dat_o, expd);
    chk(!cmd_ready, "R10 busy", cmd_ready, 0);
    wb_stall_i = (nstall > 0);
    for (int i = 0; i < nstall; i++) begin
      @(negedge clk);
      chk(wb_stb_o && wb_we_o == we && wb_adr_o == a && wb_dat_o == expd,
          "R3 held while stalled", wb_adr_o, a);
      if (i == nstall - 1) wb_stall_i = 1'b0;
    end
    if (ack_now) begin
      wb_ack_i = 1'b1; wb_dat_i = rd;
    end else begin
      @(negedge clk);
      chk(wb_cyc_o && !wb_stb_o, "R4 stb dropped", {wb_cyc_o, wb_stb_o}, 2'b10);
      if (poke_busy) begin
        cmd_valid = 1'b1; cmd_we = ~we; cmd_addr = ~a; cmd_wdata = ~wd;
      end
      for (int j = 0; j < nwait; j++) begin
        @(negedge clk);
        chk(wb_cyc_o && !wb_stb_o && !done, "R5 cyc held for ack", wb_cyc_o, 1);
        if (poke_busy)
          chk(!cmd_ready && wb_adr_o == a && wb_we_o == we, "R10 command ignored", wb_adr_o, a);
      end
      cmd_valid = 1'b0; cmd_we = 1'b0; cmd_addr = '0; cmd_wdata = '0;
      wb_ack_i = 1'b1; wb_dat_i = rd;
    end
    @(negedge clk);
    wb_ack_i = 1'b0; wb_dat_i = ~rd;
    chk(!wb_cyc_o && !wb_stb_o, ack_now ? "R12 early ack releases" : "R7 cyc released",
        wb_cyc_o, 0);
    chk(done, "R6 done pulse", done, 1);
    chk(rdata == rd, ack_now ? "R12 data captured" : "R6 data captured", rdata, rd);
    chk(!cmd_ready, "R10 not ready in done", cmd_ready, 0);
    chk(wb_adr_o == 0 && wb_dat_o == 0 && !wb_we_o, "R9 zero when idle", wb_adr_o, 0);
    @(negedge clk);
    chk(!done && !wb_cyc_o && cmd_ready, "R8 idle gap", {done, wb_cyc_o, cmd_ready}, 1);
    chk(rdata == rd, "R6 rdata holds", rdata, rd);
  endtask

  task automatic t_stray_ack();
    logic [DW-1:0] keep;
    keep = rdata;
    @(negedge clk);
    wb_ack_i = 1'b1; wb_dat_i = 32'hDEAD_0BAD;
    @(negedge clk);
    wb_ack_i = 1'b0;
    chk(!done && !wb_cyc_o, "R11 stray ack no done", done, 0);
    chk(rdata == keep, "R11 rdata unchanged", rdata, keep);
  endtask

  task automatic t_b2b();
    // command held valid across the done cycle: next request only after a gap
    @(negedge clk);
    cmd_valid = 1'b1; cmd_we = 1'b1; cmd_addr = 32'h40; cmd_wdata = 32'h1111;
    @(negedge clk);
    cmd_addr = 32'h44; cmd_wdata = 32'h2222;
    wb_ack_i = 1'b1; wb_dat_i = 32'h5;
    @(negedge clk);
    wb_ack_i = 1'b0;
    chk(!wb_cyc_o && done, "R7 first released", wb_cyc_o, 0);
    @(negedge clk);
    chk(!wb_cyc_o && cmd_ready, "R8 gap before second", wb_cyc_o, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(wb_stb_o && wb_adr_o == 32'h44 && wb_dat_o == 32'h2222, "R2 second request", wb_adr_o, 32'h44);
    wb_ack_i = 1'b1;
    @(negedge clk);
    wb_ack_i = 1'b0;
    chk(done && !wb_cyc_o, "R12 second done", done, 1);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    xfer(1'b0, 32'h0000_0010, 32'h0, 32'hCAFE_F00D, 0, 0, 1'b0, 1'b0);
    xfer(1'b1, 32'h0000_0024, 32'h1234_5678, 32'h0, 3, 2, 1'b0, 1'b0);
    xfer(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 1, 5, 1'b0, 1'b1);
    xfer(1'b1, 32'hFFFF_FFFC, 32'h0BAD_BEEF, 32'h7777_0001, 0, 0, 1'b1, 1'b0);
    xfer(1'b0, 32'h0000_0100, 32'h0, 32'h3141_5926, 2, 0, 1'b1, 1'b0);
    t_stray_ack();
    t_b2b();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule